// File: doc/BRIEF.md
# Escaped Word-Stream Frame Extractor

This block sits behind a CPU extraction queue that delivers frames as a plain stream of 32-bit words. Each frame begins with a fixed-length internal header of `HDR_WORDS` words, followed by payload words. Control information travels inside the same stream as reserved code words. These codes mark frame end (with a trim count), abort, pruning, escape and idle fill. The extractor strips the codes and recovers payload words that collide with a code value. It reads the source port out of the header and delivers the payload on a valid/ready beat interface. The final beat carries `out_last`, a 4-bit lane mask, the frame length without its 4-byte FCS, and an error flag.

Because the end marker arrives only after the last data word, the block holds one payload word back until it knows whether that word closes the frame. Frames from a source port that is out of range or not enabled are consumed up to their end marker and never reach the output. A configuration bit selects whether the comparison against code values uses the word as received or byte-reversed. Payload is always delivered exactly as received.

Top module: `wordstream_frame_extractor`

## Requirements
- R1: The first `HDR_WORDS` words after reset, and the first `HDR_WORDS` words after each frame end, are header words. They are never treated as codes and never appear on the output.
- R2: Header bytes are numbered from the start of the header, with byte 4w+j taken from bits [31-8j:24-8j] of header word w. The source port is bits [7:1] of the big-endian value formed from bytes 27..30, shifted right by 5. For the default layout this is header word 7 bits [20:14]. It appears on `out_port` for every beat of the frame.
- R3: Every other payload word is an ordinary data word. It adds 4 bytes to the count and is delivered in order with `out_keep`=4'b1111 on non-final beats. One word is held back until the next data word or end code arrives.
- R4: A word equal to 0x80000000+n (n=0..3) ends the frame. The held word is sent with `out_last`=1 and `out_keep` set to its low (4-n) bits (bit i = byte lane bits [8i+7:8i]). `out_len` is the byte count minus n minus 4, floored at 0. A frame with no data words produces a single beat with keep 4'b0000, data 0 and length 0.
- R5: The word 0x80000004 (pruned) causes the following word to be taken as literal data. That word is then the final beat, with keep 4'b1111, `out_err`=1 and length equal to the byte count minus 4.
- R6: The word 0x80000005 (abort) ends the frame without data. The held word, or an empty keep-0 beat if there is none, is sent as the final beat with `out_err`=1.
- R7: The word 0x80000006 (escape) is dropped, and the next word is delivered as data even if it matches a code.
- R8: The word 0x80000007 (not ready) is discarded. It adds nothing to the count or the output.
- R9: With `cfg_swap`=1 the code comparison uses the byte-reversed word. With `cfg_swap`=0 it uses the word as received. Data is always delivered unchanged.
- R10: If the source port is at least `NUM_PORTS`, or its `port_active` bit is 0, no beat is produced for that frame. Words are consumed, respecting escape and prune, through the frame's end code, and the next word starts a new header.
- R11: A beat is held stable while `out_valid`=1 and `out_ready`=0. `out_err` is 1 only on final beats, and `out_len` is 0 on non-final beats.
- R12: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_swap | input | 1 | Compare codes against the byte-reversed word |
| port_active | input | NUM_PORTS | Per-port enable; bit p admits frames from port p |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_data | input | 32 | Input word |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | 32 | Payload word as received |
| out_keep | output | 4 | Valid byte lanes of the beat |
| out_last | output | 1 | Final beat of the frame |
| out_err | output | 1 | Frame was pruned or aborted (final beat only) |
| out_len | output | LEN_W | Frame length without FCS (final beat only) |
| out_port | output | 7 | Source port of the frame |

## Verification
The bench targets header words that look like end or abort codes, which a decoder that runs too early would take as a frame end. It sends data words that collide with codes behind an escape. It sends a literal code after a prune, and it sends end codes on frames with zero or one data word, where a missing hold-back or an unfloored length would show up as a wrong or extra beat. It runs a byte-reversed comparison frame where an unswapped code passes through as data. It sends dropped frames whose bodies contain escaped end codes; a flush that ends at the first code-like word would leak the tail as a bogus frame. Throttled `out_ready` patterns expose beats that change or vanish while stalled.

// File: rtl/xtr_pkg.sv
package xtr_pkg;

  localparam int PORT_W      = 7;
  localparam int FIELD_BYTE  = 27;
  localparam int FIELD_SHIFT = 5;
  // stream position (from header start, MSB first) of the port's lowest bit
  localparam int PORT_BIT0_POS = FIELD_BYTE * 8 + 31 - (FIELD_SHIFT + 1);
  localparam int PORT_WORD     = PORT_BIT0_POS / 32;
  localparam int PORT_LSB      = 31 - (PORT_BIT0_POS % 32);

  localparam logic [28:0] CODE_PREFIX = 29'h1000_0000;

  typedef enum logic [2:0] {
    K_DATA, K_EOF, K_PRUNE, K_ABORT, K_ESC, K_IDLE
  } word_kind_e;

  typedef enum logic [2:0] {
    S_HDR, S_BODY, S_ESC, S_PRUNE, S_FINAL, S_DROP, S_DROP_ESC, S_DROP_PRUNE
  } xtr_state_e;

  function automatic logic [31:0] bswap32(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [3:0] keep_for_trim(input logic [1:0] t);
    logic [3:0] k;
    case (t)
      2'd0:    k = 4'b1111;
      2'd1:    k = 4'b0111;
      2'd2:    k = 4'b0011;
      default: k = 4'b0001;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/xtr_code_classify.sv
module xtr_code_classify
  import xtr_pkg::*;
(
  input  logic [31:0] word_i,
  input  logic        swap_i,
  output word_kind_e  kind_o,
  output logic [1:0]  trim_o
);

  logic [31:0] cmp;

  always_comb begin
    cmp    = swap_i ? bswap32(word_i) : word_i;
    trim_o = cmp[1:0];
    kind_o = K_DATA;
    if (cmp[31:3] == CODE_PREFIX) begin
      case (cmp[2:0])
        3'd4:    kind_o = K_PRUNE;
        3'd5:    kind_o = K_ABORT;
        3'd6:    kind_o = K_ESC;
        3'd7:    kind_o = K_IDLE;
        default: kind_o = K_EOF;
      endcase
    end
  end

endmodule

// File: rtl/xtr_hdr_capture.sv
module xtr_hdr_capture
  import xtr_pkg::*;
#(
  parameter int HDR_WORDS = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_i,
  input  logic [PORT_W-1:0] pslice_i,
  output logic              last_o,
  output logic [PORT_W-1:0] port_o
);

  localparam int CNT_W = $clog2(HDR_WORDS);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [PORT_W-1:0] port_q, port_d;
  logic              at_port_word;

  always_comb begin
    at_port_word = (cnt_q == CNT_W'(PORT_WORD));
    last_o       = (cnt_q == CNT_W'(HDR_WORDS - 1));
    port_o       = at_port_word ? pslice_i : port_q;
    cnt_d        = cnt_q;
    port_d       = port_q;
    if (shift_i) begin
      cnt_d = last_o ? '0 : cnt_q + CNT_W'(1);
      if (at_port_word) port_d = pslice_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      port_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      port_q <= port_d;
    end
  end

endmodule

// File: rtl/xtr_beat_reg.sv
module xtr_beat_reg
  import xtr_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              ready_i,
  input  logic [31:0]       data_i,
  input  logic [3:0]        keep_i,
  input  logic              last_i,
  input  logic              err_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [PORT_W-1:0] port_i,
  output logic              free_o,
  output logic              valid_o,
  output logic [31:0]       data_o,
  output logic [3:0]        keep_o,
  output logic              last_o,
  output logic              err_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [PORT_W-1:0] port_o
);

  logic valid_d;

  always_comb begin
    free_o  = !valid_o || ready_i;
    valid_d = valid_o;
    if (load_i)       valid_d = 1'b1;
    else if (ready_i) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      keep_o  <= '0;
      last_o  <= 1'b0;
      err_o   <= 1'b0;
      len_o   <= '0;
      port_o  <= '0;
    end else begin
      valid_o <= valid_d;
      if (load_i) begin
        data_o <= data_i;
        keep_o <= keep_i;
        last_o <= last_i;
        err_o  <= err_i;
        len_o  <= len_i;
        port_o <= port_i;
      end
    end
  end

endmodule

// File: rtl/wordstream_frame_extractor.sv
module wordstream_frame_extractor
  import xtr_pkg::*;
#(
  parameter int HDR_WORDS = 9,
  parameter int NUM_PORTS = 65,
  parameter int LEN_W     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_swap,
  input  logic [NUM_PORTS-1:0] port_active,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [31:0]          in_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [31:0]          out_data,
  output logic [3:0]           out_keep,
  output logic                 out_last,
  output logic                 out_err,
  output logic [LEN_W-1:0]     out_len,
  output logic [PORT_W-1:0]    out_port
);

  localparam int PORT_SPACE = 2 ** PORT_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  xtr_state_e        state_q, state_d;
  logic              pend_vld_q, pend_vld_d;
  logic [31:0]       pend_data_q, pend_data_d;
  logic [3:0]        pend_keep_q, pend_keep_d;
  logic              pend_err_q, pend_err_d;
  logic [LEN_W-1:0]  pend_len_q, pend_len_d;
  logic [LEN_W-1:0]  cnt_q, cnt_d;
  logic [PORT_W-1:0] port_q, port_d;

  word_kind_e        kind;
  logic [1:0]        trim;
  logic              hdr_shift, hdr_last;
  logic [PORT_W-1:0] hdr_port;
  logic              ofree, acc, take, port_ok;
  logic [PORT_SPACE-1:0] act_vec;
  logic [1:0]        trim_sel;
  logic [LEN_W:0]    len_diff;
  logic [LEN_W-1:0]  len_sat;

  logic              b_load, b_last, b_err;
  logic [31:0]       b_data;
  logic [3:0]        b_keep;
  logic [LEN_W-1:0]  b_len;

  xtr_code_classify u_cls (
    .word_i (in_data),
    .swap_i (cfg_swap),
    .kind_o (kind),
    .trim_o (trim)
  );

  xtr_hdr_capture #(.HDR_WORDS(HDR_WORDS)) u_hdr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .shift_i  (hdr_shift),
    .pslice_i (in_data[PORT_LSB +: PORT_W]),
    .last_o   (hdr_last),
    .port_o   (hdr_port)
  );

  xtr_beat_reg #(.LEN_W(LEN_W)) u_beat (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load_i  (b_load),
    .ready_i (out_ready),
    .data_i  (b_data),
    .keep_i  (b_keep),
    .last_i  (b_last),
    .err_i   (b_err),
    .len_i   (b_len),
    .port_i  (port_q),
    .free_o  (ofree),
    .valid_o (out_valid),
    .data_o  (out_data),
    .keep_o  (out_keep),
    .last_o  (out_last),
    .err_o   (out_err),
    .len_o   (out_len),
    .port_o  (out_port)
  );

  // admission and length arithmetic
  always_comb begin
    act_vec  = {{(PORT_SPACE - NUM_PORTS){1'b0}}, port_active};
    port_ok  = act_vec[hdr_port];
    trim_sel = (kind == K_EOF) ? trim : 2'd0;
    len_diff = {1'b0, cnt_q} - {{(LEN_W - 1){1'b0}}, trim_sel} - (LEN_W + 1)'(4);
    len_sat  = len_diff[LEN_W] ? '0 : len_diff[LEN_W-1:0];
  end

  always_comb begin
    case (state_q)
      S_HDR, S_DROP, S_DROP_ESC, S_DROP_PRUNE: in_ready = 1'b1;
      S_FINAL:                                  in_ready = 1'b0;
      default:                                  in_ready = ofree;
    endcase
    acc  = in_valid && in_ready;
    take = (state_q != S_BODY) || (kind == K_DATA);
  end

  // next-state process
  always_comb begin
    state_d     = state_q;
    pend_vld_d  = pend_vld_q;
    pend_data_d = pend_data_q;
    pend_keep_d = pend_keep_q;
    pend_err_d  = pend_err_q;
    pend_len_d  = pend_len_q;
    cnt_d       = cnt_q;
    port_d      = port_q;
    hdr_shift   = 1'b0;
    b_load      = 1'b0;
    b_data      = pend_data_q;
    b_keep      = 4'b1111;
    b_last      = 1'b0;
    b_err       = 1'b0;
    b_len       = '0;

    case (state_q)
      S_HDR: if (acc) begin
        hdr_shift = 1'b1;
        if (hdr_last) begin
          cnt_d   = '0;
          port_d  = hdr_port;
          state_d = port_ok ? S_BODY : S_DROP;
        end
      end

      S_BODY, S_ESC, S_PRUNE: if (acc) begin
        if (take) begin
          b_load      = pend_vld_q;
          pend_vld_d  = 1'b1;
          pend_data_d = in_data;
          cnt_d       = cnt_q + LEN_W'(4);
          if (state_q == S_PRUNE) begin
            state_d     = S_FINAL;
            pend_keep_d = 4'b1111;
            pend_err_d  = 1'b1;
            pend_len_d  = cnt_q;
          end else begin
            state_d = S_BODY;
          end
        end else begin
          case (kind)
            K_EOF, K_ABORT: begin
              state_d     = S_FINAL;
              pend_vld_d  = 1'b1;
              pend_err_d  = (kind == K_ABORT);
              pend_len_d  = len_sat;
              if (pend_vld_q) begin
                pend_keep_d = (kind == K_EOF) ? keep_for_trim(trim) : 4'b1111;
              end else begin
                pend_keep_d = 4'b0000;
                pend_data_d = '0;
              end
            end
            K_PRUNE: state_d = S_PRUNE;
            K_ESC:   state_d = S_ESC;
            default: state_d = state_q;
          endcase
        end
      end

      S_FINAL: if (ofree) begin
        b_load     = 1'b1;
        b_keep     = pend_keep_q;
        b_last     = 1'b1;
        b_err      = pend_err_q;
        b_len      = pend_len_q;
        pend_vld_d = 1'b0;
        state_d    = S_HDR;
      end

      S_DROP: if (acc) begin
        case (kind)
          K_EOF, K_ABORT: state_d = S_HDR;
          K_PRUNE:        state_d = S_DROP_PRUNE;
          K_ESC:          state_d = S_DROP_ESC;
          default:        state_d = S_DROP;
        endcase
      end

      S_DROP_ESC:   if (acc) state_d = S_DROP;
      S_DROP_PRUNE: if (acc) state_d = S_HDR;
      default:      state_d = S_HDR;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q     <= S_HDR;
      pend_vld_q  <= 1'b0;
      pend_data_q <= '0;
      pend_keep_q <= '0;
      pend_err_q  <= 1'b0;
      pend_len_q  <= '0;
      cnt_q       <= '0;
      port_q      <= '0;
    end else begin
      state_q     <= state_d;
      pend_vld_q  <= pend_vld_d;
      pend_data_q <= pend_data_d;
      pend_keep_q <= pend_keep_d;
      pend_err_q  <= pend_err_d;
      pend_len_q  <= pend_len_d;
      cnt_q       <= cnt_d;
      port_q      <= port_d;
    end
  end

endmodule

// File: rtl/xtr_checker.sv
module xtr_checker #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_valid,
  input logic             out_ready,
  input logic [31:0]      out_data,
  input logic [3:0]       out_keep,
  input logic             out_last,
  input logic             out_err,
  input logic [LEN_W-1:0] out_len
);

  // R11: stalled beat stays put
  a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_keep)
                                && $stable(out_last) && $stable(out_err) && $stable(out_len));

  // R3: non-final beats carry all four lanes
  a_r3_full_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_last |-> out_keep == 4'b1111);

  // R4: final lane mask is a contiguous low-lane run
  a_r4_keep_shape: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_last |-> out_keep inside {4'b0000, 4'b0001, 4'b0011, 4'b0111, 4'b1111});

  // R4: an empty final beat reports zero length
  a_r4_empty_len: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_last && out_keep == 4'b0000 |-> out_len == '0);

  // R11: error only on final beats
  a_r11_err_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> out_last);

  // R11: length only on final beats
  a_r11_len_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_last |-> out_len == '0);

endmodule

bind wordstream_frame_extractor xtr_checker #(.LEN_W(LEN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_keep  (out_keep),
  .out_last  (out_last),
  .out_err   (out_err),
  .out_len   (out_len)
);

// File: tb/wordstream_frame_extractor_test.sv
module wordstream_frame_extractor_test;

  localparam int HDR_WORDS = 9;
  localparam int NUM_PORTS = 65;
  localparam int LEN_W     = 16;

  typedef struct packed {
    logic [31:0]      d;
    logic [3:0]       k;
    logic             l;
    logic             e;
    logic [LEN_W-1:0] n;
    logic [6:0]       p;
  } beat_t;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 cfg_swap;
  logic [NUM_PORTS-1:0] port_active;
  logic                 in_valid;
  logic                 in_ready;
  logic [31:0]          in_data;
  logic                 out_valid;
  logic                 out_ready;
  logic [31:0]          out_data;
  logic [3:0]           out_keep;
  logic                 out_last;
  logic                 out_err;
  logic [LEN_W-1:0]     out_len;
  logic [6:0]           out_port;

  int    compared = 0;
  int    mismatched = 0;
  int    cyc = 0;
  int    rdy_mode = 0;
  beat_t exp_q[$];
  string tag_q[$];
  logic [31:0] dq[$];
  bit    prev_stall = 1'b0;
  beat_t prev_beat;

  always #10 clk = ~clk;   // 50 MHz

  wordstream_frame_extractor #(
    .HDR_WORDS(HDR_WORDS), .NUM_PORTS(NUM_PORTS), .LEN_W(LEN_W)
  ) uut (
    .clk(clk), .rst_n(rst_n), .cfg_swap(cfg_swap), .port_active(port_active),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_keep(out_keep), .out_last(out_last), .out_err(out_err),
    .out_len(out_len), .out_port(out_port)
  );

  function automatic logic [31:0] bsw(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [31:0] enc(input logic [31:0] c, input bit sw);
    return sw ? bsw(c) : c;
  endfunction

  function automatic logic [3:0] mask_for(input int t);
    case (t)
      0: return 4'b1111;
      1: return 4'b0111;
      2: return 4'b0011;
      default: return 4'b0001;
    endcase
  endfunction

  function automatic beat_t mk(input logic [31:0] d, input logic [3:0] k, input bit l,
                               input bit e, input int n, input int p);
    beat_t b;
    b.d = d; b.k = k; b.l = l; b.e = e; b.n = LEN_W'(n); b.p = 7'(p);
    return b;
  endfunction

  // ready pattern, changed just after each rising edge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = (cyc % 3) != 0;
      default: out_ready = (cyc % 4) < 2;
    endcase
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 60000) begin
      mismatched++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 60000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  // output monitor, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      beat_t act;
      act = mk(out_data, out_keep, out_last, out_err, int'(out_len), int'(out_port));
      if (prev_stall) begin
        compared++;
        if (!out_valid || act != prev_beat) begin
          mismatched++;
          $display("FAIL R11 stalled beat changed: actual v=%0b %h expected %h", out_valid, act, prev_beat);
        end
      end
      if (out_valid && out_ready) begin
        compared++;
        if (exp_q.size() == 0) begin
          mismatched++;
          $display("FAIL R10 unexpected beat: actual %h expected none", act);
        end else begin
          beat_t ex;
          string tg;
          ex = exp_q.pop_front();
          tg = tag_q.pop_front();
          if (act != ex) begin
            mismatched++;
            $display("FAIL %s beat: actual d=%h k=%b l=%b e=%b len=%0d p=%0d expected d=%h k=%b l=%b e=%b len=%0d p=%0d",
                     tg, act.d, act.k, act.l, act.e, act.n, act.p, ex.d, ex.k, ex.l, ex.e, ex.n, ex.p);
          end
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_beat  = act;
    end
  end

  task automatic drive(input logic [31:0] w);
    in_valid = 1'b1;
    in_data  = w;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  // endk: 0 = end code with trim, 1 = abort, 2 = prune followed by xtra
  task automatic send_frame(input int port, input int endk, input int trim,
                            input logic [31:0] xtra, input bit sw, input bit idle_fill,
                            input string tg);
    logic [31:0] wl[$];
    bit ok;
    int n;
    cfg_swap = sw;
    n = dq.size();
    // header: code-like filler (R1), port in word 7 bits [20:14] (R2)
    for (int i = 0; i < HDR_WORDS; i++) begin
      if (i == 6)      wl.push_back(32'h8000_0000);
      else if (i == 7) wl.push_back((32'hFFFF_FFFF & ~(32'h7F << 14)) | (32'(port) << 14));
      else             wl.push_back(32'h8000_0005 + 32'(i % 3));
    end
    for (int i = 0; i < n; i++) begin
      logic [31:0] c;
      c = sw ? bsw(dq[i]) : dq[i];
      if (c[31:3] == 29'h1000_0000) wl.push_back(enc(32'h8000_0006, sw));
      wl.push_back(dq[i]);
      if (idle_fill && (i % 2 == 0)) wl.push_back(enc(32'h8000_0007, sw));
    end
    if (endk == 0)      wl.push_back(enc(32'h8000_0000 | 32'(trim), sw));
    else if (endk == 1) wl.push_back(enc(32'h8000_0005, sw));
    else begin
      wl.push_back(enc(32'h8000_0004, sw));
      wl.push_back(xtra);
    end

    ok = (port < NUM_PORTS) && port_active[port];
    if (ok) begin
      for (int i = 0; i < n; i++) begin
        bit fin;
        fin = (i == n - 1) && (endk != 2);
        if (!fin) begin
          exp_q.push_back(mk(dq[i], 4'b1111, 0, 0, 0, port));
        end else if (endk == 0) begin
          int len;
          len = 4 * n - trim - 4;
          if (len < 0) len = 0;
          exp_q.push_back(mk(dq[i], mask_for(trim), 1, 0, len, port));
        end else begin
          exp_q.push_back(mk(dq[i], 4'b1111, 1, 1, (4 * n - 4 < 0) ? 0 : 4 * n - 4, port));
        end
        tag_q.push_back(tg);
      end
      if (n == 0 && endk != 2) begin
        exp_q.push_back(mk(32'h0, 4'b0000, 1, endk == 1, 0, port));
        tag_q.push_back(tg);
      end
      if (endk == 2) begin
        exp_q.push_back(mk(xtra, 4'b1111, 1, 1, 4 * n, port));
        tag_q.push_back(tg);
      end
    end
    foreach (wl[i]) drive(wl[i]);
  endtask

  initial begin
    rst_n       = 1'b0;
    cfg_swap    = 1'b0;
    in_valid    = 1'b0;
    in_data     = '0;
    out_ready   = 1'b1;
    port_active = '1;
    port_active[3] = 1'b0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12: reset state
    compared++;
    if (out_valid !== 1'b0) begin
      mismatched++;
      $display("FAIL R12 out_valid after reset: actual %b expected 0", out_valid);
    end
    compared++;
    if (in_ready !== 1'b1) begin
      mismatched++;
      $display("FAIL R12 in_ready after reset: actual %b expected 1", in_ready);
    end
    @(posedge clk); #1;

    // R3 R8 R1 R2: plain frame with idle fill, full last word
    dq = '{32'h0102_0304, 32'h1111_2222, 32'h3333_4444, 32'hDEAD_BEEF};
    send_frame(5, 0, 0, 0, 0, 1, "R3/R8");
    // R7 R4: colliding data behind escapes, trim 3
    dq = '{32'h8000_0003, 32'hCAFE_0001, 32'h8000_0006};
    send_frame(12, 0, 3, 0, 0, 0, "R7/R4");
    // R4: empty frame
    dq = '{};
    send_frame(5, 0, 2, 0, 0, 0, "R4 empty");
    // R4: single word, length floored at zero
    dq = '{32'hAABB_CCDD};
    send_frame(1, 0, 2, 0, 0, 0, "R4 floor");
    // R5: pruned, trailing word is a literal code
    dq = '{32'h0000_0001, 32'h0000_0002};
    send_frame(7, 2, 0, 32'h8000_0001, 0, 0, "R5");
    // R6: abort with and without held data
    dq = '{32'h5555_AAAA, 32'h6666_BBBB};
    send_frame(9, 1, 0, 0, 0, 0, "R6");
    dq = '{};
    send_frame(0, 1, 0, 0, 0, 0, "R6 empty");
    // R10: out-of-range port with escaped end codes inside, pruned end
    dq = '{32'h8000_0000, 32'h1234_5678, 32'h8000_0005};
    send_frame(70, 2, 0, 32'h8000_0002, 0, 0, "R10 range");
    // R10: inactive port
    dq = '{32'h7777_7777, 32'h8000_0001};
    send_frame(3, 0, 1, 0, 0, 0, "R10 inactive");
    // R9: byte-reversed code comparison
    dq = '{32'h0500_0080, 32'h8000_0005, 32'h0102_0304, 32'h0000_0000, 32'h9999_0000};
    send_frame(20, 0, 1, 0, 1, 1, "R9");
    // R11: throttled output
    rdy_mode = 1;
    dq = '{32'h1, 32'h2, 32'h3, 32'h4, 32'h5, 32'h6, 32'h7, 32'h8};
    send_frame(40, 0, 2, 0, 0, 0, "R11");
    rdy_mode = 2;
    dq = '{32'hA1, 32'hA2, 32'hA3};
    send_frame(64, 2, 0, 32'hFFFF_0000, 0, 1, "R11/R5");
    dq = '{32'hB1, 32'hB2};
    send_frame(64, 0, 0, 0, 0, 0, "R2 max port");
    rdy_mode = 0;

    for (int i = 0; i < 2000 && exp_q.size() != 0; i++) @(posedge clk);
    repeat (10) @(posedge clk);
    @(negedge clk);
    compared++;
    if (exp_q.size() != 0) begin
      mismatched++;
      $display("FAIL R10 missing beats: actual %0d left expected 0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule